// File: doc/BRIEF.md
# DDR3 Command Decoder and Bank Tracker

This block sits behind the command/address pins of a DDR3 device model or a memory-controller monitor. At every rising clock edge it samples chip select, the three command strobes, clock enable, the bank address and the address bus. It turns them into one registered command code with its qualifiers: target bank, row or column address, auto-precharge, burst chop, all-bank precharge and mode-register index. The decoded result appears in the cycle that follows the sampling edge.

Alongside the decoder, a table holds an open/idle flag and the latched row for each bank. The table applies activates, precharges and delayed auto-precharge closures. A clock-enable monitor uses the table to sort each falling clock-enable edge into one of three kinds: precharge power-down, active power-down or self-refresh entry. Two sticky flags report protocol misuse. One covers accesses to idle banks and activates to open banks. The other covers a clock-enable drop while a read or write burst is still running.

Top module: `ddr3_cmd_tracker`

## Requirements
- R1: A cycle sampled with `cs_n` high is masked: the next `cmd_code` is 0 (none), and the bank state does not change.
- R2: With `cs_n` low and `cke` high, `{ras_n,cas_n,we_n}` decodes as follows. 011 is activate (code 1), 101 is read (code 2), 100 is write (code 3), 010 is precharge (code 4), 001 is refresh (code 5) and 000 is mode-register set (code 6). 111 and 110 give code 0. The code and `out_bank` are valid in the cycle after the sampling edge.
- R3: On a read or write, `auto_pre` equals address bit 10. `out_addr` is the column address, which is the address with bits 10 and 12 forced to 0. On any other command `auto_pre` is 0.
- R4: On a precharge, `all_banks` equals address bit 10. When it is 1, every bank becomes idle. When it is 0, only the bank selected by `ba` becomes idle. On other commands `all_banks` is 0.
- R5: On a read or write, `burst_chop` is the inverse of address bit 12, so bit 12 low means a 4-beat chopped burst. On other commands `burst_chop` is 0.
- R6: On a mode-register set, `mr_sel` equals `ba` and `out_addr` carries the full address as the opcode. On other commands `mr_sel` is 0.
- R7: An activate sets `bank_open[ba]`, and the row address is stored in `bank_rows[ba*15 +: 15]`, both visible with the command output.
- R8: A read or write with auto-precharge closes its bank BL_CHOP (4) sampling edges after the command edge for a chopped burst, and BL_FULL (8) edges after it for a full burst. The bank stays open before that.
- R9: `proto_err` is set, and stays set until reset, by a read or write to an idle bank or by an activate to an open bank.
- R10: A falling `cke` (sampled high, then low) gives a one-cycle `pd_event`. The value is 3 (self-refresh) if the falling-edge cycle carries a refresh command with `cs_n` low. Otherwise it is 2 (active power-down) if any bank was open, and 1 (precharge power-down) if all banks were idle. No command is decoded while `cke` is low.
- R11: `cke_err` is set, and stays set until reset, when `cke` is sampled low on any of the 4 (chopped) or 8 (full) edges that follow a read or write command edge. A low `cke` after that window does not set it.
- R12: `rst_n` low clears, at once and without a clock, all outputs, the bank state and both error flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe command pin |
| cas_n | input | 1 | Column strobe command pin |
| we_n | input | 1 | Write-enable command pin |
| cke | input | 1 | Clock enable |
| ba | input | 3 | Bank address |
| addr | input | 15 | Address bus (bit 10 and bit 12 qualifiers) |
| cmd_code | output | 3 | Decoded command, 0 when none |
| out_bank | output | 3 | Target bank of the decoded command |
| out_addr | output | 15 | Row, column or opcode |
| auto_pre | output | 1 | Read/write with auto-precharge |
| burst_chop | output | 1 | Read/write with chopped burst |
| all_banks | output | 1 | Precharge applies to all banks |
| mr_sel | output | 3 | Mode-register index on a mode-register set |
| bank_open | output | 8 | Open flag per bank |
| bank_rows | output | 120 | Latched row per bank, 15 bits each |
| pd_event | output | 2 | Clock-enable drop kind: 1 precharge PD, 2 active PD, 3 self-refresh |
| proto_err | output | 1 | Sticky command-order error |
| cke_err | output | 1 | Sticky clock-enable drop inside a burst |

## Verification
Every decoded field, the bank flags and rows, `pd_event` and both error flags are registered once, so each one is due in the cycle after the edge that samples the stimulus. The bench drives pins on the falling edge and reads results on the next falling edge. Auto-precharge is the one result with a longer delay. Its closure comes exactly 4 or 8 edges after the command edge, so the bench reads the open flag one edge before and on the edge the closure is due. The clock-enable window is probed in the same way, on its last sampled edge and on the first edge after it.

// File: rtl/ddr3_trk_pkg.sv
package ddr3_trk_pkg;

    localparam int TRK_BANKS   = 8;
    localparam int TRK_BA_W    = $clog2(TRK_BANKS);
    localparam int TRK_ADDR_W  = 15;
    localparam int TRK_AP_BIT  = 10;
    localparam int TRK_BC_BIT  = 12;
    localparam int TRK_BL_FULL = 8;
    localparam int TRK_BL_CHOP = 4;
    localparam int TRK_CNT_W   = $clog2(TRK_BL_FULL + 1);

    typedef enum logic [2:0] {
        OP_NONE = 3'd0,
        OP_ACT  = 3'd1,
        OP_RD   = 3'd2,
        OP_WR   = 3'd3,
        OP_PRE  = 3'd4,
        OP_REF  = 3'd5,
        OP_MRS  = 3'd6
    } op_e;

    typedef enum logic [1:0] {
        PD_NONE = 2'd0,
        PD_PRE  = 2'd1,
        PD_ACT  = 2'd2,
        PD_SREF = 2'd3
    } pd_e;

    typedef struct packed {
        op_e                     op;
        logic [TRK_BA_W-1:0]     bank;
        logic [TRK_ADDR_W-1:0]   addr;
        logic                    ap;
        logic                    chop;
        logic                    all;
    } cmd_t;

    // Strobe pattern {ras_n, cas_n, we_n} to operation.
    function automatic op_e strobes_to_op(input logic r, input logic c, input logic w);
        case ({r, c, w})
            3'b011:  return OP_ACT;
            3'b101:  return OP_RD;
            3'b100:  return OP_WR;
            3'b010:  return OP_PRE;
            3'b001:  return OP_REF;
            3'b000:  return OP_MRS;
            default: return OP_NONE;
        endcase
    endfunction

    function automatic logic is_access(input op_e op);
        return (op == OP_RD) || (op == OP_WR);
    endfunction

endpackage

// File: rtl/ddr3_cmd_decode.sv
module ddr3_cmd_decode
    import ddr3_trk_pkg::*;
#(
    parameter int BA_W   = TRK_BA_W,
    parameter int ADDR_W = TRK_ADDR_W,
    parameter int AP_BIT = TRK_AP_BIT,
    parameter int BC_BIT = TRK_BC_BIT
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              ras_n,
    input  logic              cas_n,
    input  logic              we_n,
    input  logic              cke,
    input  logic [BA_W-1:0]   ba,
    input  logic [ADDR_W-1:0] addr,
    output cmd_t              dec_c,
    output logic              sref_req,
    output cmd_t              dec_q,
    output logic [BA_W-1:0]   mr_q
);

    op_e op_raw;

    always_comb begin
        op_raw   = strobes_to_op(ras_n, cas_n, we_n);
        dec_c    = '0;
        sref_req = !cs_n && !cke && (op_raw == OP_REF);
        if (!cs_n && cke && (op_raw != OP_NONE)) begin
            dec_c.op   = op_raw;
            dec_c.bank = ba;
            dec_c.addr = addr;
            case (op_raw)
                OP_RD, OP_WR: begin
                    dec_c.ap           = addr[AP_BIT];
                    dec_c.chop         = !addr[BC_BIT];
                    dec_c.addr[AP_BIT] = 1'b0;
                    dec_c.addr[BC_BIT] = 1'b0;
                end
                OP_PRE:  dec_c.all = addr[AP_BIT];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dec_q <= '0;
            mr_q  <= '0;
        end else begin
            dec_q <= dec_c;
            mr_q  <= (dec_c.op == OP_MRS) ? ba : '0;
        end
    end

endmodule

// File: rtl/ddr3_bank_table.sv
module ddr3_bank_table
    import ddr3_trk_pkg::*;
#(
    parameter int NUM_BANKS = TRK_BANKS,
    parameter int ADDR_W    = TRK_ADDR_W,
    parameter int BL_FULL   = TRK_BL_FULL,
    parameter int BL_CHOP   = TRK_BL_CHOP
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  cmd_t                        dec_c,
    output logic [NUM_BANKS-1:0]        open_vec,
    output logic [NUM_BANKS*ADDR_W-1:0] rows,
    output logic                        proto_err
);

    localparam int CNT_W = $clog2(BL_FULL + 1);

    logic [NUM_BANKS-1:0] err_vec;

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        logic             hit;
        logic [CNT_W-1:0] ap_cnt;

        assign hit        = (int'(dec_c.bank) == b);
        assign err_vec[b] = hit && (((dec_c.op == OP_ACT) && open_vec[b]) ||
                                    (is_access(dec_c.op) && !open_vec[b]));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                open_vec[b]               <= 1'b0;
                rows[b*ADDR_W +: ADDR_W]  <= '0;
                ap_cnt                    <= '0;
            end else begin
                if (ap_cnt != '0) begin
                    ap_cnt <= ap_cnt - 1'b1;
                    if (ap_cnt == CNT_W'(1)) open_vec[b] <= 1'b0;
                end
                case (dec_c.op)
                    OP_ACT: if (hit) begin
                        open_vec[b]              <= 1'b1;
                        rows[b*ADDR_W +: ADDR_W] <= dec_c.addr;
                    end
                    OP_PRE: if (hit || dec_c.all) begin
                        open_vec[b] <= 1'b0;
                        ap_cnt      <= '0;
                    end
                    OP_RD, OP_WR: if (hit && dec_c.ap) begin
                        ap_cnt <= dec_c.chop ? CNT_W'(BL_CHOP) : CNT_W'(BL_FULL);
                    end
                    default: ;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          proto_err <= 1'b0;
        else if (|err_vec)   proto_err <= 1'b1;
    end

endmodule

// File: rtl/ddr3_power_monitor.sv
module ddr3_power_monitor
    import ddr3_trk_pkg::*;
#(
    parameter int BL_FULL = TRK_BL_FULL,
    parameter int BL_CHOP = TRK_BL_CHOP
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cke,
    input  logic access,
    input  logic chop,
    input  logic sref_req,
    input  logic any_open,
    output pd_e  pd_q,
    output logic cke_err
);

    localparam int CNT_W = $clog2(BL_FULL + 1);

    logic             cke_q;
    logic [CNT_W-1:0] burst_cnt;
    pd_e              pd_n;

    always_comb begin
        pd_n = PD_NONE;
        if (cke_q && !cke) begin
            if (sref_req)      pd_n = PD_SREF;
            else if (any_open) pd_n = PD_ACT;
            else               pd_n = PD_PRE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cke_q     <= 1'b0;
            burst_cnt <= '0;
            pd_q      <= PD_NONE;
            cke_err   <= 1'b0;
        end else begin
            cke_q <= cke;
            pd_q  <= pd_n;
            if (!cke && (burst_cnt != '0)) cke_err <= 1'b1;
            if (access)                burst_cnt <= chop ? CNT_W'(BL_CHOP) : CNT_W'(BL_FULL);
            else if (burst_cnt != '0)  burst_cnt <= burst_cnt - 1'b1;
        end
    end

endmodule

// File: rtl/ddr3_cmd_tracker.sv
module ddr3_cmd_tracker
    import ddr3_trk_pkg::*;
#(
    parameter int NUM_BANKS = TRK_BANKS,
    parameter int ADDR_W    = TRK_ADDR_W,
    parameter int AP_BIT    = TRK_AP_BIT,
    parameter int BC_BIT    = TRK_BC_BIT,
    parameter int BL_FULL   = TRK_BL_FULL,
    parameter int BL_CHOP   = TRK_BL_CHOP,
    localparam int BA_W     = $clog2(NUM_BANKS)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        cs_n,
    input  logic                        ras_n,
    input  logic                        cas_n,
    input  logic                        we_n,
    input  logic                        cke,
    input  logic [BA_W-1:0]             ba,
    input  logic [ADDR_W-1:0]           addr,
    output logic [2:0]                  cmd_code,
    output logic [BA_W-1:0]             out_bank,
    output logic [ADDR_W-1:0]           out_addr,
    output logic                        auto_pre,
    output logic                        burst_chop,
    output logic                        all_banks,
    output logic [BA_W-1:0]             mr_sel,
    output logic [NUM_BANKS-1:0]        bank_open,
    output logic [NUM_BANKS*ADDR_W-1:0] bank_rows,
    output logic [1:0]                  pd_event,
    output logic                        proto_err,
    output logic                        cke_err
);

    cmd_t dec_c;
    cmd_t dec_q;
    logic sref_req;
    pd_e  pd_q;

    ddr3_cmd_decode #(
        .BA_W(BA_W), .ADDR_W(ADDR_W), .AP_BIT(AP_BIT), .BC_BIT(BC_BIT)
    ) u_decode (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
        .we_n(we_n), .cke(cke), .ba(ba), .addr(addr),
        .dec_c(dec_c), .sref_req(sref_req), .dec_q(dec_q), .mr_q(mr_sel)
    );

    ddr3_bank_table #(
        .NUM_BANKS(NUM_BANKS), .ADDR_W(ADDR_W), .BL_FULL(BL_FULL), .BL_CHOP(BL_CHOP)
    ) u_banks (
        .clk(clk), .rst_n(rst_n), .dec_c(dec_c),
        .open_vec(bank_open), .rows(bank_rows), .proto_err(proto_err)
    );

    ddr3_power_monitor #(
        .BL_FULL(BL_FULL), .BL_CHOP(BL_CHOP)
    ) u_power (
        .clk(clk), .rst_n(rst_n), .cke(cke),
        .access(is_access(dec_c.op)), .chop(dec_c.chop), .sref_req(sref_req),
        .any_open(|bank_open), .pd_q(pd_q), .cke_err(cke_err)
    );

    assign cmd_code   = dec_q.op;
    assign out_bank   = dec_q.bank;
    assign out_addr   = dec_q.addr;
    assign auto_pre   = dec_q.ap;
    assign burst_chop = dec_q.chop;
    assign all_banks  = dec_q.all;
    assign pd_event   = pd_q;

endmodule

// File: rtl/ddr3_cmd_tracker_chk.sv
module ddr3_cmd_tracker_chk
    import ddr3_trk_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       cs_n,
    input logic       cke,
    input logic [2:0] cmd_code,
    input logic [2:0] out_bank,
    input logic       auto_pre,
    input logic       burst_chop,
    input logic       all_banks,
    input logic [7:0] bank_open,
    input logic [1:0] pd_event,
    input logic       proto_err,
    input logic       cke_err
);

    logic seen;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seen <= 1'b0;
        else        seen <= 1'b1;
    end

    p_masked_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (seen && $past(cs_n)) |-> (cmd_code == 3'd0));

    p_ap_qual_r3: assert property (@(posedge clk) disable iff (!rst_n)
        auto_pre |-> ((cmd_code == 3'(OP_RD)) || (cmd_code == 3'(OP_WR))));

    p_chop_qual_r5: assert property (@(posedge clk) disable iff (!rst_n)
        burst_chop |-> ((cmd_code == 3'(OP_RD)) || (cmd_code == 3'(OP_WR))));

    p_all_close_r4: assert property (@(posedge clk) disable iff (!rst_n)
        all_banks |-> ((cmd_code == 3'(OP_PRE)) && (bank_open == 8'h00)));

    p_act_open_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_code == 3'(OP_ACT)) |-> bank_open[out_bank]);

    p_proto_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (seen && $past(proto_err)) |-> proto_err);

    p_cke_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (seen && $past(cke_err)) |-> cke_err);

    p_pd_on_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (seen && (pd_event != 2'd0)) |-> !$past(cke));

    p_no_cmd_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (seen && !$past(cke)) |-> (cmd_code == 3'd0));

endmodule

bind ddr3_cmd_tracker ddr3_cmd_tracker_chk chk_i (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .cke(cke), .cmd_code(cmd_code),
    .out_bank(out_bank), .auto_pre(auto_pre), .burst_chop(burst_chop),
    .all_banks(all_banks), .bank_open(bank_open), .pd_event(pd_event),
    .proto_err(proto_err), .cke_err(cke_err)
);

// File: tb/ddr3_cmd_tracker_tb.sv
`timescale 1ns/1ps
module ddr3_cmd_tracker_tb_top;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, cke = 1'b1;
    logic [2:0]   ba = '0;
    logic [14:0]  addr = '0;
    logic [2:0]   cmd_code, out_bank, mr_sel;
    logic [14:0]  out_addr;
    logic         auto_pre, burst_chop, all_banks, proto_err, cke_err;
    logic [7:0]   bank_open;
    logic [119:0] bank_rows;
    logic [1:0]   pd_event;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #4 clk = ~clk;

    ddr3_cmd_tracker dut_i (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
        .we_n(we_n), .cke(cke), .ba(ba), .addr(addr), .cmd_code(cmd_code),
        .out_bank(out_bank), .out_addr(out_addr), .auto_pre(auto_pre),
        .burst_chop(burst_chop), .all_banks(all_banks), .mr_sel(mr_sel),
        .bank_open(bank_open), .bank_rows(bank_rows), .pd_event(pd_event),
        .proto_err(proto_err), .cke_err(cke_err)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic drive(input logic c, input logic r, input logic ca, input logic w,
                         input logic k, input logic [2:0] b, input logic [14:0] a);
        cs_n = c; ras_n = r; cas_n = ca; we_n = w; cke = k; ba = b; addr = a;
        @(negedge clk);
    endtask

    task automatic nop(input logic k);
        drive(1'b0, 1'b1, 1'b1, 1'b1, k, 3'd0, 15'd0);
    endtask
    task automatic act(input logic [2:0] b, input logic [14:0] row);
        drive(1'b0, 1'b0, 1'b1, 1'b1, 1'b1, b, row);
    endtask
    task automatic rd(input logic [2:0] b, input logic [14:0] a);
        drive(1'b0, 1'b1, 1'b0, 1'b1, 1'b1, b, a);
    endtask
    task automatic wr(input logic [2:0] b, input logic [14:0] a);
        drive(1'b0, 1'b1, 1'b0, 1'b0, 1'b1, b, a);
    endtask
    task automatic pre(input logic [2:0] b, input logic all);
        drive(1'b0, 1'b0, 1'b1, 1'b0, 1'b1, b, all ? 15'h0400 : 15'h0000);
    endtask

    task automatic do_reset();
        cs_n = 1'b0; ras_n = 1'b1; cas_n = 1'b1; we_n = 1'b1; cke = 1'b1;
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic t_reset_state();
        do_reset();
        rst_n = 1'b0;
        #1;
        check("R12", "cmd_code in reset", 32'(cmd_code), 0);
        check("R12", "bank_open in reset", 32'(bank_open), 0);
        check("R12", "errors in reset", {30'd0, proto_err, cke_err}, 0);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic t_masked();
        drive(1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 3'd3, 15'h0123);
        check("R1", "masked cmd_code", 32'(cmd_code), 0);
        check("R1", "masked bank_open", 32'(bank_open), 0);
    endtask

    task automatic t_activate();
        act(3'd2, 15'h1234);
        check("R2", "act code", 32'(cmd_code), 1);
        check("R2", "act bank", 32'(out_bank), 2);
        check("R7", "act row out", 32'(out_addr), 32'h1234);
        check("R7", "bank_open after act", 32'(bank_open), 32'h04);
        check("R7", "row latched", 32'(bank_rows[2*15 +: 15]), 32'h1234);
    endtask

    task automatic t_access();
        rd(3'd2, 15'h1155);
        check("R2", "read code", 32'(cmd_code), 2);
        check("R3", "read column", 32'(out_addr), 32'h0155);
        check("R3", "read no ap", 32'(auto_pre), 0);
        check("R5", "read full burst", 32'(burst_chop), 0);
        wr(3'd2, 15'h0077);
        check("R2", "write code", 32'(cmd_code), 3);
        check("R5", "write chopped", 32'(burst_chop), 1);
        check("R3", "write column", 32'(out_addr), 32'h0077);
    endtask

    task automatic t_precharge();
        act(3'd5, 15'h7FFF);
        check("R7", "two banks open", 32'(bank_open), 32'h24);
        pre(3'd2, 1'b0);
        check("R4", "single pre code", 32'(cmd_code), 4);
        check("R4", "single pre all flag", 32'(all_banks), 0);
        check("R4", "single pre closes one", 32'(bank_open), 32'h20);
        pre(3'd0, 1'b1);
        check("R4", "all pre flag", 32'(all_banks), 1);
        check("R4", "all pre closes all", 32'(bank_open), 0);
        check("R9", "no protocol error yet", 32'(proto_err), 0);
    endtask

    task automatic t_mode_and_misc();
        drive(1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 3'd3, 15'h0C5A);
        check("R6", "mrs code", 32'(cmd_code), 6);
        check("R6", "mrs index", 32'(mr_sel), 3);
        check("R6", "mrs opcode", 32'(out_addr), 32'h0C5A);
        check("R3", "mrs no ap", 32'(auto_pre), 0);
        drive(1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 3'd1, 15'h0);
        check("R2", "refresh code", 32'(cmd_code), 5);
        check("R6", "mr_sel zero off mrs", 32'(mr_sel), 0);
        drive(1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 3'd1, 15'h0);
        check("R2", "pattern 110 none", 32'(cmd_code), 0);
        nop(1'b1);
        check("R2", "nop none", 32'(cmd_code), 0);
    endtask

    task automatic t_auto_precharge();
        act(3'd1, 15'h0042);
        rd(3'd1, 15'h1400);
        check("R3", "read ap set", 32'(auto_pre), 1);
        for (int i = 0; i < 7; i++) nop(1'b1);
        check("R8", "full burst still open at 7", 32'(bank_open[1]), 1);
        nop(1'b1);
        check("R8", "full burst closed at 8", 32'(bank_open[1]), 0);
        act(3'd1, 15'h0043);
        wr(3'd1, 15'h0400);
        for (int i = 0; i < 3; i++) nop(1'b1);
        check("R8", "chop still open at 3", 32'(bank_open[1]), 1);
        nop(1'b1);
        check("R8", "chop closed at 4", 32'(bank_open[1]), 0);
        check("R9", "clean sequence no error", 32'(proto_err), 0);
    endtask

    task automatic t_protocol();
        do_reset();
        rd(3'd0, 15'h0010);
        check("R9", "read idle bank", 32'(proto_err), 1);
        nop(1'b1);
        nop(1'b1);
        check("R9", "error sticky", 32'(proto_err), 1);
        do_reset();
        act(3'd3, 15'h0001);
        check("R9", "first act clean", 32'(proto_err), 0);
        act(3'd3, 15'h0002);
        check("R9", "act open bank", 32'(proto_err), 1);
    endtask

    task automatic t_power();
        do_reset();
        nop(1'b1);
        nop(1'b0);
        check("R10", "precharge pd", 32'(pd_event), 1);
        drive(1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 3'd4, 15'h0005);
        check("R10", "pd pulse ends", 32'(pd_event), 0);
        check("R10", "act ignored cke low", 32'(cmd_code), 0);
        check("R10", "bank stays idle", 32'(bank_open), 0);
        nop(1'b1);
        act(3'd4, 15'h0005);
        nop(1'b0);
        check("R10", "active pd", 32'(pd_event), 2);
        nop(1'b1);
        pre(3'd0, 1'b1);
        drive(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 3'd0, 15'h0);
        check("R10", "self refresh", 32'(pd_event), 3);
        check("R10", "no refresh decoded", 32'(cmd_code), 0);
        nop(1'b1);
        check("R11", "no cke error outside burst", 32'(cke_err), 0);
    endtask

    task automatic t_cke_window();
        do_reset();
        act(3'd0, 15'h0);
        rd(3'd0, 15'h0000);
        for (int i = 0; i < 4; i++) nop(1'b1);
        nop(1'b0);
        check("R11", "drop after chop window", 32'(cke_err), 0);
        nop(1'b1);
        rd(3'd0, 15'h0000);
        for (int i = 0; i < 3; i++) nop(1'b1);
        nop(1'b0);
        check("R11", "drop on last chop edge", 32'(cke_err), 1);
        nop(1'b1);
        check("R11", "cke error sticky", 32'(cke_err), 1);
    endtask

    task automatic t_async_reset();
        do_reset();
        act(3'd6, 15'h0ABC);
        rd(3'd0, 15'h0);
        #1;
        rst_n = 1'b0;
        #1;
        check("R12", "async clears banks", 32'(bank_open), 0);
        check("R12", "async clears error", 32'(proto_err), 0);
        check("R12", "async clears row", 32'(bank_rows[6*15 +: 15]), 0);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        @(negedge clk);
        t_reset_state();
        t_masked();
        t_activate();
        t_access();
        t_precharge();
        t_mode_and_misc();
        t_auto_precharge();
        t_protocol();
        t_power();
        t_cke_window();
        t_async_reset();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule